// File: doc/BRIEF.md
# Edge-Interval Pulse-Rate Multiplier

This block turns a slow square wave into a pulse train one hundred times faster. Each input transition, rising or falling, closes one measured interval and opens the next. The block places a fixed number of evenly spaced single-clock pulses (fifty by default) into every interval. Two edges per input period therefore yield a hundredfold output rate.

A fast system-clock counter measures the time between two edges. That length sets the pulse spacing for a following interval. A phase accumulator spreads the pulses. On every clock it adds the pulse count and compares the sum with the stored length. When the sum reaches the length, it subtracts the length and fires one pulse.

The block has two pacing modes:
- **Predictive mode.** The interval just completed is used as the estimate for the interval now running. If the input speeds up, the pulses still owed are dropped at the next edge.
- **Lag mode.** Each completed interval is replayed with its own exact length. Its pulses start in the following interval, so the pulse count is always complete at the cost of one interval of latency.

The `locked` output shows when the pulse train can be trusted. It is set once two full intervals have been measured. It is cleared when the counter saturates or when an interval is too short to hold every pulse.

Top module: `edge_rate_mult`

## Requirements
- R1: The input passes two synchronizing flops. Every transition of either polarity ends one interval and starts the next. The measured length equals the number of clocks between the two transitions.
- R2: In predictive mode, with a steady interval of D clocks, each interval after lock carries exactly PULSES output pulses. The pulses of the interval that starts on the input transition sampled at clock c are visible from cycle c+4 through the cycle three clocks after the next transition.
- R3: Within a steady interval of D clocks, the gap between consecutive pulses is always floor(D/PULSES) or ceil(D/PULSES) clocks.
- R4: In predictive mode, an interval of D clocks predicted as P clocks carries min(PULSES, floor(PULSES*D/P)) pulses. Pulses still owed at the next edge are dropped, and emission stops after the PULSES-th pulse.
- R5: In lag mode (`lag_mode`=1), every completed interval from the second one onward produces exactly PULSES pulses, paced by its own length. An edge that arrives while a batch is still running is held and replayed afterwards, so no pulse is dropped.
- R6: After reset, `pulse_out` and `locked` are 0. `locked` rises only at the edge that completes the second measured interval. No pulse appears while `locked` has been 0 for two cycles.
- R7: The interval counter saturates at 2^CNT_W-1. On saturation, `locked` clears and pulses stop. Two further complete intervals are needed before `locked` returns.
- R8: An interval shorter than PULSES clocks clears `locked` and cancels the running batch. Two further complete intervals are needed before `locked` returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the input |
| rst_n | input | 1 | Synchronous reset, active low |
| sig_in | input | 1 | Asynchronous square-wave input |
| lag_mode | input | 1 | 0: predictive pacing, 1: replay each interval one interval late |
| pulse_out | output | 1 | Single-clock output pulses |
| locked | output | 1 | Two valid intervals measured; pulse train valid |

## Verification
The embedded properties rely on the following assumptions about the inputs:
- `sig_in` is low while reset is held.
- `lag_mode` changes only during reset.
- Apart from the deliberate short-interval case, intervals are at least PULSES clocks long, so the accumulator never needs to fire twice in one clock.

The stimulus respects these assumptions in several ways. It changes inputs only on falling clock edges and sets the mode inside each reset. Random intervals are drawn between 200 and 1500 clocks, with small drifts and occasional jumps. The short interval and the saturating silence are produced in separate directed phases, each preceded by its own reset.

// File: rtl/erm_pkg.sv
// Shared defaults and the pacing-mode encoding for the pulse-rate multiplier.
package erm_pkg;
    localparam int ERM_PULSES = 50;   // pulses per input interval
    localparam int ERM_CNT_W  = 17;   // interval counter width
    localparam int ERM_SYNC   = 2;    // synchronizer depth

    typedef enum logic {
        PACE_PREDICT = 1'b0,
        PACE_LAG     = 1'b1
    } pace_e;
endpackage

// File: rtl/erm_edge_sync.sv
// Synchronizes the asynchronous input and flags every transition of either
// polarity for one clock. Assumes the input is low while reset is held.
module erm_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sig_async,
    output logic edge_o
);
    // Shift chain: STAGES synchronizing flops plus one history flop.
    logic [STAGES:0] chain;

    // Purpose: move the input through the synchronizer and history flop.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-1:0], sig_async};
    end

    assign edge_o = chain[STAGES] ^ chain[STAGES-1];
endmodule

// File: rtl/erm_interval_meter.sv
// Counts clocks between synchronized edges, tracks how many valid intervals
// have been seen, and tells the pulse generator when to start or abandon a
// batch. Assumes edge_i is a one-clock strobe per transition.
module erm_interval_meter #(
    parameter int CNT_W  = 17,
    parameter int PULSES = 50
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             edge_i,
    output logic [CNT_W-1:0] len_o,
    output logic             load_o,
    output logic             kill_o,
    output logic             locked_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] MIN_LEN = CNT_W'(PULSES);

    logic [CNT_W-1:0] cnt;
    logic             started;
    logic [1:0]       valid_cnt;
    logic             too_short;
    logic             saturated;

    assign too_short = edge_i && started && (cnt < MIN_LEN);
    assign saturated = !edge_i && (cnt == CNT_MAX);

    // Purpose: measure intervals and count valid ones, restarting on faults.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt       <= '0;
            started   <= 1'b0;
            valid_cnt <= '0;
        end else if (edge_i) begin
            cnt     <= CNT_W'(1);
            started <= 1'b1;
            if (started) begin
                if (cnt < MIN_LEN)           valid_cnt <= '0;
                else if (valid_cnt != 2'd2)  valid_cnt <= valid_cnt + 2'd1;
            end
        end else if (cnt == CNT_MAX) begin
            started   <= 1'b0;
            valid_cnt <= '0;
        end else begin
            cnt <= cnt + CNT_W'(1);
        end
    end

    assign len_o    = cnt;
    assign load_o   = edge_i && started && (cnt >= MIN_LEN) && (valid_cnt != 2'd0);
    assign kill_o   = too_short || saturated;
    assign locked_o = (valid_cnt == 2'd2);

    // R7: a saturated counter holds its value and the lock is lost.
    a_r7_cnt_saturates: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == CNT_MAX && !edge_i) |=> (cnt == CNT_MAX && !locked_o));

    // R8: an interval shorter than the pulse count drops the lock.
    a_r8_short_unlocks: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_i && started && cnt < MIN_LEN) |=> !locked_o);
endmodule

// File: rtl/erm_pulse_nco.sv
// Spreads PULSES single-clock pulses over a stored interval length with a
// phase accumulator. In predictive mode a new length replaces the running
// batch at once; in lag mode it waits in a one-deep holding slot until the
// running batch is complete. Assumes every loaded length is >= PULSES.
module erm_pulse_nco
    import erm_pkg::*;
#(
    parameter int CNT_W  = 17,
    parameter int PULSES = 50
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lag_mode,
    input  logic             load_i,
    input  logic [CNT_W-1:0] len_i,
    input  logic             kill_i,
    output logic             pulse_o
);
    localparam int ACC_W = CNT_W + 1;
    localparam int PCW   = $clog2(PULSES + 1);

    logic [CNT_W-1:0] period;
    logic [ACC_W-1:0] acc;
    logic [ACC_W-1:0] acc_sum;
    logic [PCW-1:0]   pcnt;
    logic             active;
    logic [CNT_W-1:0] pend_len;
    logic             pend_v;
    logic             fire;
    logic             last;
    logic             free;
    logic             direct;

    assign acc_sum = acc + ACC_W'(PULSES);
    assign fire    = active && (acc_sum >= {1'b0, period});
    assign last    = fire && (pcnt == PCW'(PULSES - 1));
    assign free    = !active || last;
    assign direct  = load_i && ((pace_e'(lag_mode) == PACE_PREDICT) || (free && !pend_v));

    // Purpose: advance the accumulator, fire pulses and start new batches.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            period   <= '0;
            acc      <= '0;
            pcnt     <= '0;
            active   <= 1'b0;
            pend_len <= '0;
            pend_v   <= 1'b0;
            pulse_o  <= 1'b0;
        end else begin
            pulse_o <= fire;
            if (kill_i) begin
                active <= 1'b0;
                pend_v <= 1'b0;
                acc    <= '0;
                pcnt   <= '0;
            end else begin
                if (active) begin
                    if (fire) begin
                        acc  <= acc_sum - {1'b0, period};
                        pcnt <= pcnt + PCW'(1);
                        if (last) active <= 1'b0;
                    end else begin
                        acc <= acc_sum;
                    end
                end
                if (direct) begin
                    period <= len_i;
                    acc    <= '0;
                    pcnt   <= '0;
                    active <= 1'b1;
                end else if (free && pend_v) begin
                    period <= pend_len;
                    acc    <= '0;
                    pcnt   <= '0;
                    active <= 1'b1;
                    pend_v <= load_i;
                    if (load_i) pend_len <= len_i;
                end else if (load_i) begin
                    pend_len <= len_i;
                    pend_v   <= 1'b1;
                end
            end
        end
    end

    // R2: a batch never holds more than PULSES pulses.
    a_r2_batch_cap: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> (pcnt < PCW'(PULSES)));

    // R3: the residual phase stays below the interval length.
    a_r3_phase_bound: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> (acc < {1'b0, period}));

    // R5: a held interval in lag mode survives until the batch completes.
    a_r5_lag_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (lag_mode && pend_v && active && !last && !kill_i) |=> pend_v);
endmodule

// File: rtl/edge_rate_mult.sv
// Top level of the edge-interval pulse-rate multiplier: synchronizer and
// edge detector, interval meter, and pulse accumulator. Assumes sig_in is
// low during reset and lag_mode changes only during reset.
module edge_rate_mult
    import erm_pkg::*;
#(
    parameter int CNT_W  = ERM_CNT_W,
    parameter int PULSES = ERM_PULSES,
    parameter int SYNC   = ERM_SYNC
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sig_in,
    input  logic lag_mode,
    output logic pulse_out,
    output logic locked
);
    logic             edge_w;
    logic [CNT_W-1:0] len_w;
    logic             load_w;
    logic             kill_w;

    erm_edge_sync #(.STAGES(SYNC)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .sig_async (sig_in),
        .edge_o    (edge_w)
    );

    erm_interval_meter #(.CNT_W(CNT_W), .PULSES(PULSES)) u_meter (
        .clk      (clk),
        .rst_n    (rst_n),
        .edge_i   (edge_w),
        .len_o    (len_w),
        .load_o   (load_w),
        .kill_o   (kill_w),
        .locked_o (locked)
    );

    erm_pulse_nco #(.CNT_W(CNT_W), .PULSES(PULSES)) u_nco (
        .clk      (clk),
        .rst_n    (rst_n),
        .lag_mode (lag_mode),
        .load_i   (load_w),
        .len_i    (len_w),
        .kill_i   (kill_w),
        .pulse_o  (pulse_out)
    );

    // R6: no pulse once the lock has been absent for two cycles.
    a_r6_quiet_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
        (!locked && !$past(locked)) |-> !pulse_out);
endmodule

// File: tb/edge_rate_mult_tb.sv
module edge_rate_mult_tb;
    localparam int CNT_W  = 12;
    localparam int PULSES = 50;
    localparam int LOGN   = 200000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sig_in = 1'b0;
    logic lag_mode = 1'b0;
    logic pulse_out;
    logic locked;

    int  cyc = 0;
    int  checks = 0;
    int  errors = 0;
    bit  done = 1'b0;
    bit  plog [0:LOGN-1];
    int  seg[$];

    edge_rate_mult #(.CNT_W(CNT_W), .PULSES(PULSES)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .sig_in    (sig_in),
        .lag_mode  (lag_mode),
        .pulse_out (pulse_out),
        .locked    (locked)
    );

    always #4 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    // Sample the output away from the active edge.
    always @(negedge clk) if (cyc < LOGN) plog[cyc] <= pulse_out;

    function automatic int exp_count(input int d, input int p);
        int n;
        n = (PULSES * d) / p;
        return (n > PULSES) ? PULSES : n;
    endfunction

    function automatic int count_window(input int a, input int b);
        int n;
        n = 0;
        for (int k = a; k <= b; k++) if (k >= 0 && k < LOGN && plog[k]) n++;
        return n;
    endfunction

    task automatic check_eq(input string tag, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    task automatic do_reset(input logic mode);
        rst_n    = 1'b0;
        sig_in   = 1'b0;
        lag_mode = mode;
        seg.delete();
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic toggle();
        seg.push_back(cyc);
        sig_in = ~sig_in;
    endtask

    task automatic step(input int d);
        toggle();
        repeat (d) @(negedge clk);
    endtask

    // Predictive-mode per-interval count check over the current segment.
    task automatic check_pred(input string tag);
        for (int i = 2; i + 1 < seg.size(); i++) begin
            int d;
            int p;
            d = seg[i+1] - seg[i];
            p = seg[i] - seg[i-1];
            check_eq(tag, count_window(seg[i] + 4, seg[i+1] + 3), exp_count(d, p));
        end
    endtask

    task automatic drive_seq();
        int lens[7] = '{600, 600, 600, 300, 600, 600, 600};
        foreach (lens[i]) step(lens[i]);
        toggle();
        repeat (2500) @(negedge clk);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got %0d expected %0d", 190000, 0);
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int t;
        int lo;
        int hi;
        int prev;
        int d;
        int seed;
        seed = $urandom(32'd7741);

        // Phase 1: reset state, lock timing, steady predictive run with both edge polarities.
        do_reset(1'b0);
        check_eq("R6 reset pulse_out", int'(pulse_out), 0);
        check_eq("R6 reset locked", int'(locked), 0);
        step(437);
        step(437);
        check_eq("R6 no lock after one interval", int'(locked), 0);
        toggle();
        repeat (5) @(negedge clk);
        check_eq("R6 lock after two intervals", int'(locked), 1);
        repeat (432) @(negedge clk);
        for (int i = 0; i < 4; i++) step(437);
        toggle();
        repeat (600) @(negedge clk);
        check_eq("R6 no pulses before lock", count_window(0, seg[2] + 3), 0);
        check_pred("R2 R1 steady both polarities");
        // R3: gaps inside one steady window
        lo = 437 / PULSES;
        hi = (437 + PULSES - 1) / PULSES;
        prev = -1;
        t = 0;
        for (int k = seg[3] + 4; k <= seg[4] + 3; k++) begin
            if (plog[k]) begin
                if (prev >= 0 && (k - prev < lo || k - prev > hi)) t++;
                prev = k;
            end
        end
        check_eq("R3 gap outside floor/ceil", t, 0);

        // Phase 2: predictive, one short interval drops pulses.
        do_reset(1'b0);
        drive_seq();
        check_pred("R4 predictive shrink");
        check_eq("R4 predictive total", count_window(seg[2] + 4, cyc), 6 * PULSES - 25);

        // Phase 3: same sequence in lag mode keeps every pulse.
        do_reset(1'b1);
        drive_seq();
        check_eq("R5 lag total", count_window(seg[2] + 4, cyc), 6 * PULSES);
        check_eq("R5 lag first batch", count_window(seg[2] + 4, seg[3] + 3), PULSES);

        // Phase 4: constrained random intervals in predictive mode.
        do_reset(1'b0);
        d = 800;
        for (int i = 0; i < 30; i++) begin
            if ($urandom_range(0, 5) == 0) d = $urandom_range(200, 1500);
            else d = d + $urandom_range(0, 120) - 60;
            if (d < 200) d = 200;
            if (d > 1500) d = 1500;
            step(d);
        end
        toggle();
        repeat (1600) @(negedge clk);
        check_pred("R4 R2 random intervals");

        // Phase 5: counter saturation drops the lock, then relock.
        do_reset(1'b0);
        for (int i = 0; i < 4; i++) step(300);
        toggle();
        t = seg[4];
        repeat (3000) @(negedge clk);
        check_eq("R7 lock held before saturation", int'(locked), 1);
        repeat (1200) @(negedge clk);
        check_eq("R7 lock lost on saturation", int'(locked), 0);
        check_eq("R7 silent after batch", count_window(t + 310, cyc), 0);
        step(300);
        step(300);
        repeat (5) @(negedge clk);
        check_eq("R7 one interval not enough", int'(locked), 0);
        repeat (295) @(negedge clk);
        toggle();
        repeat (5) @(negedge clk);
        check_eq("R7 relock after two intervals", int'(locked), 1);

        // Phase 6: an interval below PULSES clocks.
        do_reset(1'b0);
        for (int i = 0; i < 4; i++) step(300);
        step(30);
        t = seg[5];
        toggle();
        repeat (5) @(negedge clk);
        check_eq("R8 short interval unlocks", int'(locked), 0);
        repeat (295) @(negedge clk);
        check_eq("R8 batch cancelled", count_window(seg[5] + 4, cyc), 0);
        toggle();
        repeat (5) @(negedge clk);
        check_eq("R8 one interval not enough", int'(locked), 0);
        repeat (295) @(negedge clk);
        toggle();
        repeat (5) @(negedge clk);
        check_eq("R8 relock after two intervals", int'(locked), 1);
        if (t < 0) $display("unreachable");

        done = 1'b1;
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule